// File: doc/BRIEF.md
# Timed Parallel Port Engine

This block turns a group of eight single-bit lines into a general-purpose 8-bit parallel port that is controlled through byte streams. Bytes arriving on the input stream are placed on the port one at a time. A prescaler timer sets the pace: it produces one tick every `prescale + 1` clock cycles, and the port can change only on a tick. The port lines are read back and delivered on an output stream of bytes. A per-line direction mask decides which lines the block drives. A line that is not driven returns its external level when read.

The block has two read modes. In free-running mode the port is sampled on every tick, whether or not bytes are being written. In lockstep mode a sample is taken only when a byte is written. That sample holds the port as it was just before the new byte replaced it, so every output byte pairs with one input byte. Two active-low strobes, one for writes and one for reads, each go low for a single clock after the port access they mark. External logic can use them as clocks.

Top module: `bitbang_port`

## Requirements
- R1: While reset is high and in the cycle after it is released, `pin_out` and `pin_oe` are 0, `wr_n` and `rd_n` are 1 and `out_valid` is 0.
- R2: A port access (write or sample) can only happen on a timer tick. Ticks are spaced `prescale + 1` clock cycles apart, so consecutive free-running samples mark `rd_n` low exactly `prescale + 1` cycles apart.
- R3: While `out_valid` is 1 and `out_ready` is 0, no new sample is taken, `out_data` stays unchanged and `rd_n` stays 1. No sample is lost or overwritten.
- R4: One cycle after `dir_mask` is applied, `pin_oe` equals it. A sampled bit is taken from `pin_out` where `pin_oe` is 1, and from `pin_in` where it is 0. `pin_in` passes through a two-stage synchronizer first.
- R5: A byte is accepted when `in_valid` and `in_ready` are both 1 at a clock edge. In the next cycle `pin_out` equals that byte and `wr_n` is 0 for exactly that one cycle.
- R6: When no byte is accepted, `pin_out` keeps its last value and `wr_n` stays 1.
- R7: In lockstep mode (`sync_mode` = 1), each accepted byte produces exactly one output byte. That output byte is the read-back of the port taken before the new byte is applied. `rd_n` goes low in the same cycle as `wr_n`. No sample is taken without a write.
- R8: In lockstep mode, while an output byte is waiting (`out_valid` = 1), `in_ready` stays 0 and no input byte is accepted.
- R9: In free-running mode (`sync_mode` = 0), the port is sampled on every tick at which `out_valid` is 0. This happens independently of writes, which are still accepted on every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale | input | PRESC_W | Tick period minus one, in clock cycles |
| sync_mode | input | 1 | 1 = lockstep sampling, 0 = free-running sampling |
| dir_mask | input | WIDTH | Per-line drive enable |
| in_valid | input | 1 | Input stream byte present |
| in_data | input | WIDTH | Input stream byte |
| in_ready | output | 1 | Input byte is taken at this edge |
| out_valid | output | 1 | Output stream byte present |
| out_data | output | WIDTH | Sampled port byte |
| out_ready | input | 1 | Consumer takes the output byte |
| pin_in | input | WIDTH | External line levels |
| pin_out | output | WIDTH | Driven line levels |
| pin_oe | output | WIDTH | Line output enables |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The bench builds the block with `WIDTH` = 8 and `PRESC_W` = 8, and runs it with a prescale of 3. A tick therefore arrives every four cycles, which is short enough to test the pacing, the stall windows and many samples within a short run. Lockstep writes are scored against a queue of predicted read-backs under direction masks of all-driven, half-driven and all-input. Free-running samples are scored against the applied line levels.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic {
    BB_FREE = 1'b0,
    BB_LOCK = 1'b1
  } bb_mode_e;
endpackage

// File: rtl/bb_tick_gen.sv
module bb_tick_gen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] prescale,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= prescale) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R2: ticks are spaced apart unless the period is a single cycle
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || $past(prescale) == '0));
endmodule

// File: rtl/bb_pin_sampler.sv
module bb_pin_sampler #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] pin_out,
  input  logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] read_val
);
  localparam int STAGES = 2;
  logic [WIDTH-1:0] sync_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign read_val[b] = pin_oe[b] ? pin_out[b] : sync_q[STAGES-1][b];
  end
endmodule

// File: rtl/bb_sequencer.sv
module bb_sequencer
  import bb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sync_mode,
  input  logic [WIDTH-1:0] dir_mask,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic [WIDTH-1:0] read_val,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             wr_n,
  output logic             rd_n
);
  bb_mode_e mode;
  logic     do_write;
  logic     do_read;

  assign mode     = bb_mode_e'(sync_mode);
  assign in_ready = tick && (mode == BB_FREE || !out_valid);
  assign do_write = in_valid && in_ready;
  assign do_read  = (mode == BB_LOCK) ? do_write : (tick && !out_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out   <= '0;
      pin_oe    <= '0;
      wr_n      <= 1'b1;
      rd_n      <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      pin_oe <= dir_mask;
      wr_n   <= !do_write;
      rd_n   <= !do_read;
      if (do_write) pin_out <= in_data;
      if (do_read) begin
        out_data  <= read_val;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5: a write strobe only follows a timer tick
  a_r5_wr_after_tick: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> $past(tick));
  // R3: a waiting sample is neither dropped nor replaced
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R6: port holds when nothing was taken
  a_r6_port_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(pin_out));
  // R7: lockstep reads are paired with writes
  a_r7_lock_pair: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(sync_mode)) |-> !wr_n);
  // R8: lockstep refuses input while a sample waits
  a_r8_lock_stall: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && out_valid) |-> !in_ready);
endmodule

// File: rtl/bitbang_port.sv
module bitbang_port #(
  parameter int WIDTH   = 8,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               sync_mode,
  input  logic [WIDTH-1:0]   dir_mask,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [WIDTH-1:0]   out_data,
  input  logic               out_ready,
  input  logic [WIDTH-1:0]   pin_in,
  output logic [WIDTH-1:0]   pin_out,
  output logic [WIDTH-1:0]   pin_oe,
  output logic               wr_n,
  output logic               rd_n
);
  logic             tick;
  logic [WIDTH-1:0] read_val;

  bb_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .prescale (prescale),
    .tick     (tick)
  );

  bb_pin_sampler #(.WIDTH(WIDTH)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .read_val (read_val)
  );

  bb_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .sync_mode (sync_mode),
    .dir_mask  (dir_mask),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .read_val  (read_val),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .wr_n      (wr_n),
    .rd_n      (rd_n)
  );

  // R1: strobes are idle and nothing is driven in the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (wr_n && rd_n && !out_valid && pin_oe == '0));
endmodule

// File: tb/bitbang_port_tb.sv
module bitbang_port_tb;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int PW    = 8;
  localparam int PRESC = 3;

  logic          clk = 0;
  logic          rst;
  logic [PW-1:0] prescale;
  logic          sync_mode;
  logic [W-1:0]  dir_mask, in_data, out_data, pin_in, pin_out, pin_oe;
  logic          in_valid, in_ready, out_valid, out_ready, wr_n, rd_n;

  int total = 0, bad = 0, async_seen = 0;
  logic [W-1:0] exp_q[$];
  logic         async_chk = 0;
  logic [W-1:0] async_val;
  logic [W-1:0] prev_out = '0;

  always #(CLK_P/2) clk = ~clk;

  bitbang_port #(.WIDTH(W), .PRESC_W(PW)) u_dut (
    .clk(clk), .rst(rst), .prescale(prescale), .sync_mode(sync_mode),
    .dir_mask(dir_mask), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .wr_n(wr_n), .rd_n(rd_n)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [W-1:0] e;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(out_data == e, "R7 lockstep sample", out_data, e);
      end else if (async_chk) begin
        async_seen++;
        chk(out_data == async_val, "R9 free-running sample", out_data, async_val);
      end
    end
  end

  task automatic send(input logic [W-1:0] b);
    logic [W-1:0] e;
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
    if (sync_mode) begin
      e = (prev_out & pin_oe) | (pin_in & ~pin_oe);
      exp_q.push_back(e);
    end
    @(negedge clk);
    in_valid = 0;
    chk(pin_out == b, "R5 port value", pin_out, b);
    chk(wr_n == 0, "R5 write strobe", {7'b0, wr_n}, 8'h00);
    if (sync_mode) chk(rd_n == 0, "R7 read strobe with write", {7'b0, rd_n}, 8'h00);
    prev_out = b;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, gap;
    logic [W-1:0] held;
    bit ok;
    rst = 1; prescale = PRESC; sync_mode = 1; dir_mask = 8'hFF;
    in_valid = 0; in_data = 0; out_ready = 1; pin_in = 8'hA5;
    wait_cyc(5);
    chk(pin_out == 0 && pin_oe == 0, "R1 pins idle in reset", pin_out | pin_oe, 8'h00);
    @(negedge clk); rst = 0;
    chk(wr_n && rd_n && !out_valid, "R1 strobes idle", {5'b0, wr_n, rd_n, out_valid}, 8'h06);
    wait_cyc(2);
    chk(pin_oe == 8'hFF, "R4 direction applied", pin_oe, 8'hFF);

    // lockstep mode
    send(8'h11); send(8'h22); send(8'h33);
    wait_cyc(PRESC + 2);
    chk(wr_n == 1, "R6 no strobe when empty", {7'b0, wr_n}, 8'h01);
    chk(pin_out == 8'h33, "R6 port holds", pin_out, 8'h33);
    dir_mask = 8'h0F; wait_cyc(3);
    send(8'h4C);                    // expect A3
    dir_mask = 8'h00; wait_cyc(3);
    send(8'h5D);                    // expect A5
    pin_in = 8'h3C;
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid && exp_q.size() == 0) ok = 0;
    end
    chk(ok, "R7 no sample without write", {7'b0, out_valid}, 8'h00);
    chk(exp_q.size() == 0, "R7 one sample per write", exp_q.size(), 8'h00);

    // free-running mode
    async_val = 8'h3C; async_chk = 1; sync_mode = 0;
    wait_cyc(40);
    chk(async_seen >= 8, "R9 samples on ticks", async_seen, 8'h08);
    @(negedge clk);
    while (!(rd_n == 0)) @(negedge clk);
    t0 = $time / CLK_P;
    @(negedge clk);
    while (!(rd_n == 0)) @(negedge clk);
    gap = $time / CLK_P - t0;
    chk(gap == PRESC + 1, "R2 tick spacing", gap, PRESC + 1);
    send(8'h77);
    wait_cyc(12);
    chk(pin_out == 8'h77, "R9 writes while sampling", pin_out, 8'h77);

    // output stall
    out_ready = 0; wait_cyc(2 * (PRESC + 1));
    held = out_data;
    chk(out_valid == 1, "R3 sample waiting", {7'b0, out_valid}, 8'h01);
    async_chk = 0; pin_in = 8'hC3;
    ok = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rd_n == 0) ok = 0;
    end
    chk(ok, "R3 no read strobe while full", {7'b0, rd_n}, 8'h01);
    chk(out_data == held, "R3 waiting data kept", out_data, held);
    sync_mode = 1; in_valid = 1; in_data = 8'hEE; ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (in_ready) ok = 0;
    end
    in_valid = 0;
    chk(ok, "R8 input refused while full", {7'b0, in_ready}, 8'h00);
    chk(pin_out == 8'h77, "R8 port unchanged", pin_out, 8'h77);
    sync_mode = 0;
    @(negedge clk);
    chk(out_data == held, "R3 held sample delivered", out_data, held);
    out_ready = 1;
    wait_cyc(20);
    async_val = 8'hC3; async_seen = 0; async_chk = 1;
    wait_cyc(30);
    chk(async_seen >= 4, "R9 sampling resumes", async_seen, 8'h04);
    async_chk = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule